// File: doc/BRIEF.md
# Colour Lookup Table with Register Programming Port

This block holds a 256-entry colour table in which every entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software programs the table over a small register bus that uses 32-bit writes. A write to the pointer register picks the entry to load. Three writes to the colour register then fill red, green and blue in that order. After blue, the pointer moves to the next entry by itself, so a block of colours can be loaded as one uninterrupted stream of colour writes.

The pixel pipeline uses a separate lookup port. It presents an 8-bit pixel code with a valid strobe, and one cycle later it receives the 24-bit colour held for that code. Neither port ever applies back-pressure. Each ready output goes high on the first clock edge after reset is released and then stays high. A request is accepted in every cycle in which its valid input is high, and no request waits. Register reads are accepted but always return zero. After reset the table shows black in every entry except the last, which shows white.

Top module: `palette_dac`

## Requirements
- R1: A write to byte offset 0 loads the entry pointer from write data bits 31:24 and returns the colour phase to red. The remaining data bits are ignored.
- R2: A write to byte offset 4 stores write data bits 31:24 into one colour component of the entry the pointer selects. The other two components of that entry are left unchanged, so a lookup made between colour writes returns a partly updated colour.
- R3: Colour writes fill red first, then green, then blue. A pointer write made partway through that sequence restarts it at red.
- R4: The blue write advances the pointer by one and returns the phase to red. Pointer 255 advances to 0.
- R5: A read returns zero on `bus_rdata` and changes neither the pointer nor the phase. A write to any byte offset other than 0 and 4 inside the 16-byte window changes no state. This includes offsets 8 and 12 and unaligned offsets.
- R6: While reset is asserted, the table is set to black (0x000000) in entries 0 to 254 and to white (0xFFFFFF) in entry 255. The pointer is cleared to 0 and the phase to red.
- R7: A lookup accepted at a clock edge sets `px_valid` after that edge. `px_rgb` then carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0. In a cycle with no accepted lookup, `px_valid` is low on the next cycle.
- R8: A lookup accepted at the same edge as a colour write to the same entry returns the colour as it was before that write. A lookup in the following cycle returns the updated colour.
- R9: `bus_ready` and `lk_ready` are low during reset. They go high at the first clock edge after reset is released and stay high, so every valid request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Register access accepted (high after reset) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted (high after reset) |
| lk_code | input | 8 | Pixel code to look up |
| px_valid | output | 1 | Looked-up colour valid |
| px_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, 8-bit components and a 32-bit data bus. With these values the top entry is reachable. The bench can therefore observe the white reset colour at code 255 and the pointer wrapping from 255 to 0 after a blue write. The full-size table also lets the bench stream back-to-back lookups and compare each result with an independent model. It covers the same-edge write and lookup on one entry, and it checks that reads and writes to unused offsets leave the colour sequence intact.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // byte offsets decoded inside the register window
  localparam int unsigned OFS_POINTER = 0;
  localparam int unsigned OFS_COLOUR  = 4;
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              accept_rdy,
  output logic              hit_ptr,
  output logic              hit_col
);
  import pal_pkg::*;

  logic wr_fire;

  // ready comes up one edge after reset release and stays up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept_rdy <= 1'b0;
    else        accept_rdy <= 1'b1;
  end

  assign wr_fire = bus_valid && accept_rdy && bus_write;
  assign hit_ptr = wr_fire && (bus_addr == ADDR_W'(OFS_POINTER));
  assign hit_col = wr_fire && (bus_addr == ADDR_W'(OFS_COLOUR));
endmodule

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_ptr,
  input  logic              hit_col,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  ptr,
  output pal_pkg::phase_e   phase,
  output logic [2:0]        comp_we,
  output logic [COMP_W-1:0] comp_val
);
  import pal_pkg::*;

  assign comp_val = wdata[DATA_W-1 -: COMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= PH_RED;
    end else if (hit_ptr) begin
      ptr   <= wdata[DATA_W-1 -: IDX_W];
      phase <= PH_RED;
    end else if (hit_col) begin
      unique case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          ptr   <= ptr + 1'b1;
        end
      endcase
    end
  end

  // bit 0 red, bit 1 green, bit 2 blue
  always_comb begin
    comp_we = 3'b000;
    if (hit_col) begin
      unique case (phase)
        PH_RED:  comp_we = 3'b001;
        PH_GRN:  comp_we = 3'b010;
        default: comp_we = 3'b100;
      endcase
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          comp_we,
  input  logic [IDX_W-1:0]    wr_ptr,
  input  logic [COMP_W-1:0]   wr_val,
  input  logic                rd_fire,
  input  logic [IDX_W-1:0]    rd_code,
  output logic                rd_valid,
  output logic [3*COMP_W-1:0] rd_rgb
);
  localparam int ENTRIES = 1 << IDX_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_fire;
  end

  // c = 0 red (top bits), 1 green, 2 blue
  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [COMP_W-1:0] tbl [ENTRIES];
    logic [COMP_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++)
          tbl[i] <= (i == ENTRIES - 1) ? '1 : '0;
      end else if (comp_we[c]) begin
        tbl[wr_ptr] <= wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_fire) rd_q <= tbl[rd_code];
    end

    assign rd_rgb[(2-c)*COMP_W +: COMP_W] = rd_q;
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [IDX_W-1:0]    lk_code,
  output logic                px_valid,
  output logic [3*COMP_W-1:0] px_rgb
);
  logic              hit_ptr;
  logic              hit_col;
  logic              accept_rdy;
  logic [IDX_W-1:0]  cur_ptr;
  pal_pkg::phase_e   cur_phase;
  logic [2:0]        comp_we;
  logic [COMP_W-1:0] comp_val;

  pal_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .accept_rdy(accept_rdy), .hit_ptr(hit_ptr), .hit_col(hit_col)
  );

  pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit_ptr(hit_ptr), .hit_col(hit_col),
    .wdata(bus_wdata), .ptr(cur_ptr), .phase(cur_phase),
    .comp_we(comp_we), .comp_val(comp_val)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .wr_ptr(cur_ptr),
    .wr_val(comp_val), .rd_fire(lk_valid && accept_rdy), .rd_code(lk_code),
    .rd_valid(px_valid), .rd_rgb(px_rgb)
  );

  assign bus_ready = accept_rdy;
  assign lk_ready  = accept_rdy;
  assign bus_rdata = '0;
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              px_valid,
  input logic [IDX_W-1:0]  cur_ptr,
  input logic [1:0]        cur_phase
);
  logic unused_wd;
  logic wr_ptr_hit;
  logic wr_col_hit;
  assign unused_wd  = ^bus_wdata;
  assign wr_ptr_hit = bus_valid && bus_ready && bus_write && (bus_addr == ADDR_W'(0));
  assign wr_col_hit = bus_valid && bus_ready && bus_write && (bus_addr == ADDR_W'(4));

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_hit |=> (cur_ptr == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (cur_phase == 2'd0)); // R1

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_col_hit && cur_phase == 2'd0) |=> (cur_phase == 2'd1)); // R3

  AST_PHASE_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_col_hit && cur_phase == 2'd1) |=> (cur_phase == 2'd2) && $stable(cur_ptr)); // R3

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_col_hit && cur_phase == 2'd2) |=> (cur_ptr == $past(cur_ptr) + 1'b1) && (cur_phase == 2'd0)); // R4

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ptr_hit || wr_col_hit) |=> $stable(cur_ptr) && $stable(cur_phase)); // R5

  AST_PX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> px_valid); // R7

  AST_PX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !px_valid); // R7

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (bus_ready && lk_ready)); // R9
endmodule

bind palette_dac palette_dac_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .px_valid(px_valid),
  .cur_ptr(cur_ptr), .cur_phase(cur_phase)
);

// File: tb/test_palette_dac.sv
module test_palette_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [7:0]  lk_code = '0;
  logic        px_valid;
  logic [23:0] px_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // independent model of the table
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_ptr;
  int         m_ph;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  palette_dac i_palette_dac (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_code(lk_code), .px_valid(px_valid), .px_rgb(px_rgb)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [3:0] a, input logic [31:0] d);
    if (a == 4'd0) begin
      m_ptr = d[31:24];
      m_ph  = 0;
    end else if (a == 4'd4) begin
      case (m_ph)
        0: begin m_r[m_ptr] = d[31:24]; m_ph = 1; end
        1: begin m_g[m_ptr] = d[31:24]; m_ph = 2; end
        default: begin m_b[m_ptr] = d[31:24]; m_ph = 0; m_ptr = m_ptr + 8'd1; end
      endcase
    end
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 check(bus_rdata == 32'd0, tag, bus_rdata, 32'd0);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic lk(input logic [7:0] code, input string tag);
    lk_valid = 1'b1; lk_code = code;
    exp_q.push_back({m_r[code], m_g[code], m_b[code]});
    tag_q.push_back(tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && px_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected px_valid", {8'h0, px_rgb}, 32'h0);
      end else begin
        automatic logic [23:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(px_rgb == e, t, {8'h0, px_rgb}, {8'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = m_r[i];
      m_b[i] = m_r[i];
    end
    m_ptr = 8'd0; m_ph = 0;

    // reset state
    repeat (3) @(negedge clk);
    check(bus_ready == 1'b0 && lk_ready == 1'b0, "R9 ready low in reset", {30'd0, bus_ready, lk_ready}, 32'd0);
    check(px_valid == 1'b0, "R6 px_valid low in reset", {31'd0, px_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_ready == 1'b1 && lk_ready == 1'b1, "R9 ready high after reset", {30'd0, bus_ready, lk_ready}, 32'd3);

    // R6 reset palette
    lk(8'd0, "R6 entry 0 black");
    lk(8'd255, "R6 entry 255 white");
    lk(8'd128, "R6 entry 128 black");
    lk(8'd254, "R6 entry 254 black");

    // R6 pointer and phase cleared: first colour write lands on entry 0 red
    wr(4'd4, 32'hAA00_0000);
    lk(8'd0, "R6 pointer cleared, red first");

    // R1, R2, R3 sequence with partial colour visible
    wr(4'd0, 32'h0512_3456);
    wr(4'd4, 32'h11FF_FFFF);
    lk(8'd5, "R2 partial after red");
    wr(4'd4, 32'h2200_0000);
    lk(8'd5, "R2 partial after green");
    wr(4'd4, 32'h3300_0000);
    lk(8'd5, "R3 full colour");
    lk(8'd6, "R4 next entry untouched");
    wr(4'd4, 32'h4400_0000);
    lk(8'd6, "R4 pointer advanced after blue");

    // R3 restart by pointer write
    wr(4'd0, 32'h0900_0000);
    wr(4'd4, 32'h1000_0000);
    wr(4'd4, 32'h2000_0000);
    wr(4'd0, 32'h0900_0000);
    wr(4'd4, 32'h3000_0000);
    lk(8'd9, "R3 pointer write restarts at red");

    // R5 reads and ignored offsets
    wr(4'd0, 32'h0C00_0000);
    wr(4'd4, 32'h0100_0000);
    rd(4'd4, "R5 read colour offset returns zero");
    rd(4'd0, "R5 read pointer offset returns zero");
    wr(4'd8, 32'h7700_0000);
    wr(4'd12, 32'h7800_0000);
    wr(4'd5, 32'h7900_0000);
    wr(4'd1, 32'h7A00_0000);
    wr(4'd4, 32'h0200_0000);
    wr(4'd4, 32'h0300_0000);
    lk(8'd12, "R5 reads and other offsets left sequence intact");
    lk(8'd13, "R5 pointer advanced once");

    // R4 wrap
    wr(4'd0, 32'hFF00_0000);
    wr(4'd4, 32'h0A00_0000);
    wr(4'd4, 32'h0B00_0000);
    wr(4'd4, 32'h0C00_0000);
    lk(8'd255, "R4 entry 255 loaded");
    wr(4'd4, 32'h5A00_0000);
    lk(8'd0, "R4 pointer wrapped to 0");

    // R8 same-edge write and lookup
    wr(4'd0, 32'h1400_0000);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h9900_0000;
    lk_valid = 1'b1; lk_code = 8'd20;
    exp_q.push_back({m_r[20], m_g[20], m_b[20]});
    tag_q.push_back("R8 same-edge lookup sees old colour");
    model_wr(4'd4, 32'h9900_0000);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; lk_valid = 1'b0;
    lk(8'd20, "R8 next lookup sees new colour");

    // R7 back-to-back stream
    for (int i = 0; i < 8; i++) lk(8'(i), "R7 streamed lookup");
    for (int i = 250; i < 256; i++) lk(8'(i), "R7 streamed lookup high codes");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all lookups answered", exp_q.size(), 32'd0);
    check(px_valid == 1'b0, "R7 px_valid idle", {31'd0, px_valid}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule